// File: doc/BRIEF.md
# Half-Clock-State Bus Read Sequencer

This block is the read side of a bus master. A core asks for a read by pulsing a start request with an address. The block then steps through eight half-clock states, S0 to S7. It moves to a new state on every clock edge. Even-numbered states begin on a rising edge and odd-numbered states begin on a falling edge. The core gets the captured word back together with a one-state done indication.

On the bus side the block works in this order. It floats the address bus in S0 and drives the new address from S1 to the end of the cycle. It pulls the address strobe and the data strobe low together from S2. It samples the data bus on the falling edge that closes S6. It releases both strobes in S7, while the address is still being driven. An active-low transfer acknowledge is sampled at the end of S4. While it reads high, the block stretches the cycle by whole clocks. A request that arrives during a cycle is kept and started right after S7.

Top module: `hs_read_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, the bus address enable is 0, as_no and ds_no are 1 and done_o is 0. Asserting rst_ni in the middle of a cycle forces this state at once and discards any queued request.
- R2: When start_i is high at a rising edge with the block idle, S0 begins at that edge. Each later half-state begins on the next clock edge, so odd states begin on falling edges. After S7 with nothing queued, the block returns to idle.
- R3: bus_addr_oe_o is 0 in S0 and while idle. It is 1 from S1 through S7, and during that time bus_addr_o equals the address accepted for that cycle and does not change.
- R4: as_no is 0 from S2 through S6, including wait states, and 1 at all other times. It is never 0 while the address bus is floated.
- R5: During a read, ds_no has the same value as as_no in every half-state.
- R6: rd_data_o takes the value of bus_data_i sampled at the falling edge that ends S6. It keeps that value until the next such edge.
- R7: done_o is 1 only in S7. In that half-state both strobes are 1, the address is still driven, and rd_data_o already holds the captured word.
- R8: If ta_ni is 1 at the falling edge that ends S4, or at the falling edge that ends a wait pair, one full clock of wait states is inserted and both strobes stay low. With ta_ni 0 at that edge, the block goes on to S5. A read with w inserted waits therefore lasts 8+2w half-states.
- R9: A start_i pulse taken during a cycle is held, together with its address. The next cycle's S0 then begins on the rising edge that ends S7, and it drives the held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges advance the sequence |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request, sampled on rising edges |
| addr_i | input | ADDR_W | Read address, taken with start_i |
| rd_data_o | output | DATA_W | Captured read word |
| done_o | output | 1 | High during S7 |
| bus_addr_o | output | ADDR_W | Address bus value |
| bus_addr_oe_o | output | 1 | Address bus drive enable |
| as_no | output | 1 | Address strobe, active low |
| ds_no | output | 1 | Data strobe, active low |
| bus_data_i | input | DATA_W | Data bus |
| ta_ni | input | 1 | Transfer acknowledge, active low |

## Verification
The bench drives each read and checks every output in the middle of each half-state. Because of this, a state register that misses or repeats an edge shows up at the ports within half a clock: the address enable or a strobe changes one half-state early or late. If the capture edge is wrong, the word on rd_data_o in S7 is the decoy value the bench places on the data bus just before or just after the correct edge. If the queue is wrong, a chained cycle either fails to start on the rising edge after S7 or drives a stale address in S1.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_S0   = 4'd1,
    ST_S1   = 4'd2,
    ST_S2   = 4'd3,
    ST_S3   = 4'd4,
    ST_S4   = 4'd5,
    ST_S5   = 4'd6,
    ST_S6   = 4'd7,
    ST_S7   = 4'd8,
    ST_WO   = 4'd9,   // wait, odd half (begins falling)
    ST_WE   = 4'd10   // wait, even half (begins rising)
  } hsr_state_e;
endpackage

// File: rtl/hsr_state_core.sv
module hsr_state_core
  import hsr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       ta_ni,
  output hsr_state_e state_o,
  output logic       accept_o
);
  // dual-edge register: state = rise half xor fall half
  logic [3:0] p_q, n_q;
  hsr_state_e cur, nxt_r, nxt_f;

  assign cur      = hsr_state_e'(p_q ^ n_q);
  assign state_o  = cur;
  assign accept_o = go_i && (cur == ST_IDLE || cur == ST_S7);

  always_comb begin
    nxt_r = cur;
    unique case (cur)
      ST_IDLE, ST_S7: nxt_r = go_i ? ST_S0 : ST_IDLE;
      ST_S1:          nxt_r = ST_S2;
      ST_S3:          nxt_r = ST_S4;
      ST_S5:          nxt_r = ST_S6;
      ST_WO:          nxt_r = ST_WE;
      default:        nxt_r = cur;
    endcase
  end

  always_comb begin
    nxt_f = cur;
    unique case (cur)
      ST_S0:        nxt_f = ST_S1;
      ST_S2:        nxt_f = ST_S3;
      ST_S4, ST_WE: nxt_f = ta_ni ? ST_WO : ST_S5;
      ST_S6:        nxt_f = ST_S7;
      default:      nxt_f = cur;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) p_q <= '0;
    else         p_q <= nxt_r ^ n_q;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) n_q <= '0;
    else         n_q <= nxt_f ^ p_q;

  assert_even_rise_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cur inside {ST_IDLE, ST_S0, ST_S2, ST_S4, ST_S6, ST_WE});
  assert_odd_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur inside {ST_IDLE, ST_S1, ST_S3, ST_S5, ST_S7, ST_WO});
  assert_wait_insert_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ((cur == ST_S4 || cur == ST_WE) && ta_ni) |=> cur == ST_WE);
  assert_wait_exit_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ((cur == ST_S4 || cur == ST_WE) && !ta_ni) |=> cur == ST_S6);
endmodule

// File: rtl/hsr_req_queue.sv
module hsr_req_queue #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              accept_i,
  output logic              go_o,
  output logic [ADDR_W-1:0] cyc_addr_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q, cyc_addr_q;

  assign go_o       = start_i | pend_q;
  assign cyc_addr_o = cyc_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      cyc_addr_q  <= '0;
    end else if (accept_i) begin
      cyc_addr_q <= pend_q ? pend_addr_q : addr_i;
      pend_q     <= pend_q && start_i;
      if (pend_q && start_i) pend_addr_q <= addr_i;
    end else if (start_i && !pend_q) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_i;
    end
  end

  assert_pend_served_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && accept_i) |=> cyc_addr_q == $past(pend_addr_q));
endmodule

// File: rtl/hsr_bus_drive.sv
module hsr_bus_drive
  import hsr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hsr_state_e        state_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_addr_oe_o,
  output logic              as_no,
  output logic              ds_no,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              strobe_on;
  logic [DATA_W-1:0] data_q;

  assign bus_addr_o    = cyc_addr_i;
  assign bus_addr_oe_o = !(state_i inside {ST_IDLE, ST_S0});
  assign strobe_on     = state_i inside {ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_WO, ST_WE};
  assign as_no         = !strobe_on;
  assign ds_no         = !strobe_on;   // read cycle: same timing as address strobe
  assign done_o        = (state_i == ST_S7);
  assign rd_data_o     = data_q;

  // capture on the falling edge that closes S6
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni)                data_q <= '0;
    else if (state_i == ST_S6)  data_q <= bus_data_i;

  assert_strobe_needs_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_no |-> bus_addr_oe_o);
  assert_addr_stable_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (bus_addr_oe_o && $past(bus_addr_oe_o)) |-> $stable(bus_addr_o));
  assert_done_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (as_no && ds_no && bus_addr_oe_o));
  assert_data_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rd_data_o));
endmodule

// File: rtl/hs_read_seq.sv
module hs_read_seq
  import hsr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_addr_oe_o,
  output logic              as_no,
  output logic              ds_no,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              ta_ni
);
  hsr_state_e        state;
  logic              go, accept;
  logic [ADDR_W-1:0] cyc_addr;

  hsr_req_queue #(.ADDR_W(ADDR_W)) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .accept_i(accept), .go_o(go), .cyc_addr_o(cyc_addr)
  );

  hsr_state_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .ta_ni(ta_ni),
    .state_o(state), .accept_o(accept)
  );

  hsr_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .cyc_addr_i(cyc_addr),
    .bus_data_i(bus_data_i), .bus_addr_o(bus_addr_o), .bus_addr_oe_o(bus_addr_oe_o),
    .as_no(as_no), .ds_no(ds_no), .done_o(done_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/hs_read_seq_bench.sv
module hs_read_seq_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              done_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic              bus_addr_oe_o;
  logic              as_no, ds_no;
  logic [DATA_W-1:0] bus_data_i = 16'h5A5A;
  logic              ta_ni = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;
  logic [DATA_W-1:0] last_data = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  hs_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hs_read_seq (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string tag);
    chk({tag, " oe"}, 32'(bus_addr_oe_o), 0);
    chk({tag, " as"}, 32'(as_no), 1);
    chk({tag, " ds"}, 32'(ds_no), 1);
    chk({tag, " done"}, 32'(done_o), 0);
  endtask

  // one read: w waits; queued = request already pending; nxt = queue next
  task automatic run_read(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int w,
                          bit queued, bit nxt, logic [ADDR_W-1:0] na);
    int n = 8 + 2*w;
    if (!queued) begin
      @(posedge clk_i); #2;
      chk_idle("R2 idle");
      start_i = 1'b1; addr_i = a;
    end
    for (int h = 0; h < n; h++) begin
      bit exp_oe, exp_low, exp_done;
      if (h % 2 == 0) @(posedge clk_i); else @(negedge clk_i);
      #2;
      exp_oe   = (h >= 1);
      exp_low  = (h >= 2) && (h <= n-2);
      exp_done = (h == n-1);
      chk(h <= 1 ? "R2 oe edge" : "R3 oe", 32'(bus_addr_oe_o), 32'(exp_oe));
      if (exp_oe) chk(queued ? "R9 addr" : "R3 addr", 32'(bus_addr_o), 32'(a));
      chk((h >= 5 && h < 5+2*w) ? "R8 as" : "R4 as", 32'(as_no), 32'(!exp_low));
      chk("R5 ds", 32'(ds_no), 32'(!exp_low));
      chk("R7 done", 32'(done_o), 32'(exp_done));
      chk("R6 data", 32'(rd_data_o), exp_done ? 32'(d) : 32'(last_data));
      if (h == 0) start_i = 1'b0;
      if (h == 3 && nxt) begin start_i = 1'b1; addr_i = na; end
      if (h == 4 && nxt) start_i = 1'b0;
      ta_ni = 1'b1;
      if (h >= 4 && h % 2 == 0 && h <= 4+2*w) ta_ni = (h == 4+2*w) ? 1'b0 : 1'b1;
      if (h == n-2) bus_data_i = d;
      else          bus_data_i = ~d;
    end
    last_data = d;
  endtask

  initial begin
    bit prev_nxt = 1'b0;
    logic [ADDR_W-1:0] a_cur = 24'h100000;
    #(CLK_P*2 + 2);
    chk_idle("R1 in reset");
    @(posedge clk_i); #2; rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk_idle("R1 released");
    chk("R1 data", 32'(rd_data_o), 0);

    for (int k = 0; k < 12; k++) begin
      bit nxt = (k % 3 == 1);
      logic [ADDR_W-1:0] a_nxt = 24'h100000 + ADDR_W'((k+1) * 24'h01357B);
      logic [DATA_W-1:0] d = 16'hA000 + DATA_W'(k * 16'h0913);
      run_read(a_cur, d, k % 4, prev_nxt, nxt, a_nxt);
      prev_nxt = nxt;
      a_cur = a_nxt;
    end

    // reset in the middle of a cycle with a request queued
    @(posedge clk_i); #2; start_i = 1'b1; addr_i = 24'hABCDEF;
    @(posedge clk_i); #2; addr_i = 24'h123456;
    @(posedge clk_i); #2; start_i = 1'b0;
    @(negedge clk_i); #2; rst_ni = 1'b0; #1;
    chk_idle("R1 async");
    @(posedge clk_i); #2; rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); #2;
      chk_idle("R1 queue cleared");
    end

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P*20000);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule